// File: doc/BRIEF.md
# Isochronous IN Endpoint Double Buffer

This block holds transmit data for one isochronous IN endpoint of a USB device. It has two equal byte buffers. The CPU side fills one of them, the foreground buffer, through a byte-write port. The packet engine reads the other one, the background buffer, when the host asks this endpoint for data. A single-cycle start-of-frame pulse swaps the roles of the two buffers. The buffer that was just filled becomes the background buffer. The buffer that was background becomes the new foreground buffer and starts empty, so software never has to empty it by hand.

On the serializer side the block shows the background byte count and the byte at the current read position. Each read strobe moves the read position by one byte. The serializer reports a completed packet with a done pulse. A missed-transfer flag is updated at each frame pulse and then held for the whole frame that follows.

An endpoint-clear command is the only way to throw away written data. It empties both buffers. If a packet is being drained when the clear arrives, the block pulses a request that makes the serializer corrupt the packet on the wire with a bit-stuffing violation. Because isochronous traffic has no handshake, the handshake status outputs and the handshake interrupt are fixed at zero.

Top module: `iso_in_ep_buf`

## Requirements
- R1: After a synchronous reset, `tx_busy`, `miss_in` and `force_stuff_err` are 0 and `tx_len` is 0.
- R2: Bytes written with `wr_en` go into the foreground buffer. After the next `sof` pulse, `tx_len` equals the number of bytes accepted, and draining returns those bytes in the order they were written.
- R3: Once the foreground buffer holds `DEPTH` bytes, further writes are discarded. The count stays at `DEPTH` and the first `DEPTH` bytes are kept unchanged.
- R4: At a `sof` pulse the old background buffer becomes the foreground buffer and starts empty. A byte written in the same cycle as `sof` becomes the first byte of that new foreground buffer.
- R5: An `in_token` while idle, with no packet yet completed in the current frame, sets `tx_busy` on the next cycle with the read position at byte 0. `tx_data` shows the byte at the read position. Each `rd_strobe` moves the position by one byte. Once the position reaches `tx_len` it stops moving, and from then on `tx_data` reads 0.
- R6: A `tx_done` pulse while busy clears `tx_busy` on the next cycle. Any further `in_token` in the same frame is ignored, and `tx_busy` stays 0.
- R7: At each `sof`, `miss_in` is set to 1 if the background buffer held at least one byte and no packet was completed in the ending frame. Otherwise it is set to 0. `miss_in` does not change between `sof` pulses.
- R8: `clear_ep` empties both buffers and cancels any transfer. `tx_len` reads 0 on the next cycle, a write in the same cycle is dropped, and the next frame's background buffer is empty.
- R9: A `clear_ep` while `tx_busy` is 1 makes `force_stuff_err` 1 for exactly the following cycle. A `clear_ep` while idle leaves it at 0.
- R10: `hs_stall`, `hs_nak`, `hs_ack` and `hs_irq` are always 0.
- R11: A `sof` that arrives while a packet is still draining ends the transfer (`tx_busy` becomes 0 on the next cycle) and counts as a miss under R7.
- R12: When `clear_ep` and `sof` come in the same cycle, `miss_in` becomes 0 and both buffers are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sof | input | 1 | Start-of-frame pulse, one cycle |
| clear_ep | input | 1 | Endpoint clear command, one cycle |
| wr_en | input | 1 | CPU byte write strobe |
| wr_data | input | 8 | CPU write byte |
| in_token | input | 1 | IN token for this endpoint, one cycle |
| rd_strobe | input | 1 | Serializer consumed the byte on `tx_data` |
| tx_done | input | 1 | Serializer finished the packet |
| tx_busy | output | 1 | A packet is being drained |
| tx_len | output | LEN_W (7) | Byte count of the background buffer |
| tx_data | output | 8 | Byte at the current read position |
| force_stuff_err | output | 1 | Request to corrupt the packet with a stuffing error |
| miss_in | output | 1 | Previous frame's data was not delivered |
| hs_stall | output | 1 | Handshake stall status, always 0 |
| hs_nak | output | 1 | Handshake NAK status, always 0 |
| hs_ack | output | 1 | Handshake ACK status, always 0 |
| hs_irq | output | 1 | Handshake-result interrupt, always 0 |

## Verification
The buffering path is tried with four write patterns:
- A short packet that is drained completely. This separates correct byte order and count from a swap that is off by one frame.
- An overfilled buffer, where 70 bytes are offered to 64 places. This shows whether excess bytes are dropped or wrap over earlier data.
- A write in the same cycle as `sof`. This tells whether the new foreground buffer was emptied before or after the write landed.
- Writes followed by a clear. This tells a discarded buffer apart from one that survives into the next frame.

Frames with a completed packet, no token at all, a packet cut off by `sof`, and a clear that lands on `sof` distinguish the three outcomes of the miss flag. A clear during draining is set against a clear while idle to isolate the corruption pulse.

// File: rtl/iso_in_pkg.sv
// Shared types for the isochronous IN endpoint buffer.
// Assumes byte-wide CPU and serializer data paths.
package iso_in_pkg;
    typedef logic [7:0] byte_t;
    localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/iso_in_bank.sv
// One transmit byte buffer with a fill counter.
// Writes append at the fill count. Writes past DEPTH are dropped.
// A clear resets the count; a write in the clear cycle lands at index 0.
// The read side is combinational and returns 0 at or past the fill count.
// Assumes DEPTH >= 2.
module iso_in_bank
    import iso_in_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  byte_t         wr_data,
    input  logic [CW-1:0] rd_addr,
    output logic [CW-1:0] count,
    output byte_t         rd_data
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    byte_t         mem [DEPTH];
    logic          room;
    logic [AW-1:0] wr_idx;

    assign room   = (count < DEPTH_C);
    assign wr_idx = clr ? '0 : count[AW-1:0];

    // Fill counter: cleared by clr, advanced by each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= wr_en ? CW'(1) : '0;
        end else if (wr_en && room) begin
            count <= count + CW'(1);
        end
    end

    // Storage write: only accepted bytes are stored.
    always_ff @(posedge clk) begin
        if (wr_en && (clr || room)) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Read port: valid bytes only, zero beyond the fill count.
    always_comb begin
        if (rd_addr < count) begin
            rd_data = mem[rd_addr[AW-1:0]];
        end else begin
            rd_data = '0;
        end
    end
endmodule

// File: rtl/iso_in_ctrl.sv
// Frame and transfer control for the isochronous IN buffer.
// Holds which bank the CPU fills, the drain state, the read position,
// the per-frame sent flag, the missed-transfer flag and the corruption pulse.
// Assumes sof, clear_ep, in_token and tx_done are single-cycle pulses.
module iso_in_ctrl #(
    parameter int unsigned CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sof,
    input  logic          clear_ep,
    input  logic          in_token,
    input  logic          rd_strobe,
    input  logic          tx_done,
    input  logic [CW-1:0] bg_len,
    output logic          fg_sel,
    output logic          busy,
    output logic [CW-1:0] rd_ptr,
    output logic          miss,
    output logic          force_err
);
    logic sent;
    logic done_now;

    assign done_now = busy && tx_done;

    // Bank role: flip which bank the CPU fills at every frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fg_sel <= 1'b0;
        end else if (sof) begin
            fg_sel <= ~fg_sel;
        end
    end

    // Drain state: start on a token, end on done, sof or clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (sof || clear_ep || done_now) begin
            busy <= 1'b0;
        end else if (!busy && in_token && !sent) begin
            busy <= 1'b1;
        end
    end

    // Read position: reset at each start, advanced by strobes up to the length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (sof || clear_ep || !busy) begin
            rd_ptr <= '0;
        end else if (rd_strobe && !tx_done && (rd_ptr < bg_len)) begin
            rd_ptr <= rd_ptr + CW'(1);
        end
    end

    // Sent flag: one packet per frame, rearmed by the frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sent <= 1'b0;
        end else if (sof) begin
            sent <= 1'b0;
        end else if (done_now && !clear_ep) begin
            sent <= 1'b1;
        end
    end

    // Missed-transfer flag: decided at each frame pulse, held until the next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss <= 1'b0;
        end else if (sof) begin
            miss <= !clear_ep && (bg_len != '0) && !(sent || done_now);
        end
    end

    // Corruption request: one cycle after a clear that hits a live transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            force_err <= 1'b0;
        end else begin
            force_err <= clear_ep && busy;
        end
    end
endmodule

// File: rtl/iso_in_ep_buf.sv
// Double-buffered transmit store for one isochronous IN endpoint.
// The CPU fills the foreground bank. The serializer drains the background bank.
// The banks swap on sof, and the bank coming to the foreground is emptied.
// No handshake exists for this transfer type, so handshake status is tied low.
// Assumes the serializer takes one byte per rd_strobe and signals tx_done.
module iso_in_ep_buf
    import iso_in_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             clear_ep,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             in_token,
    input  logic             rd_strobe,
    input  logic             tx_done,
    output logic             tx_busy,
    output logic [LEN_W-1:0] tx_len,
    output logic [7:0]       tx_data,
    output logic             force_stuff_err,
    output logic             miss_in,
    output logic             hs_stall,
    output logic             hs_nak,
    output logic             hs_ack,
    output logic             hs_irq
);
    logic             fg_sel;
    logic [LEN_W-1:0] rd_ptr;
    logic [LEN_W-1:0] bank_cnt  [NUM_BANKS];
    byte_t            bank_rd   [NUM_BANKS];
    logic             bank_wr   [NUM_BANKS];
    logic             bank_clr  [NUM_BANKS];

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic is_fg;
            assign is_fg = (fg_sel == 1'(b));
            // Write steering: in a sof cycle, writes go to the bank about to become foreground.
            assign bank_wr[b]  = wr_en && !clear_ep && (sof ? !is_fg : is_fg);
            // Emptying: on a clear, or when this bank moves to the foreground.
            assign bank_clr[b] = clear_ep || (sof && !is_fg);

            iso_in_bank #(
                .DEPTH (DEPTH),
                .CW    (LEN_W)
            ) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr     (bank_clr[b]),
                .wr_en   (bank_wr[b]),
                .wr_data (wr_data),
                .rd_addr (rd_ptr),
                .count   (bank_cnt[b]),
                .rd_data (bank_rd[b])
            );
        end
    endgenerate

    // Serializer view: the background bank's length and current byte.
    assign tx_len  = bank_cnt[~fg_sel];
    assign tx_data = bank_rd[~fg_sel];

    iso_in_ctrl #(
        .CW (LEN_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sof       (sof),
        .clear_ep  (clear_ep),
        .in_token  (in_token),
        .rd_strobe (rd_strobe),
        .tx_done   (tx_done),
        .bg_len    (tx_len),
        .fg_sel    (fg_sel),
        .busy      (tx_busy),
        .rd_ptr    (rd_ptr),
        .miss      (miss_in),
        .force_err (force_stuff_err)
    );

    // Handshake status: never produced for this transfer type.
    assign hs_stall = 1'b0;
    assign hs_nak   = 1'b0;
    assign hs_ack   = 1'b0;
    assign hs_irq   = 1'b0;
endmodule

// File: rtl/iso_in_ep_buf_checker.sv
// Temporal checks on the isochronous IN buffer ports. Attached by bind.
module iso_in_ep_buf_checker #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned LEN_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sof,
    input logic             clear_ep,
    input logic             in_token,
    input logic             tx_done,
    input logic             tx_busy,
    input logic [LEN_W-1:0] tx_len,
    input logic             force_stuff_err,
    input logic             miss_in
);
    a_r3_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
        tx_len <= LEN_W'(DEPTH));

    a_r5_start_on_token: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(in_token));

    a_r6_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && tx_done) |=> !tx_busy);

    a_r7_miss_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sof |=> $stable(miss_in));

    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear_ep |=> (tx_len == '0) && !tx_busy);

    a_r9_force_cause: assert property (@(posedge clk) disable iff (!rst_n)
        force_stuff_err |-> $past(clear_ep && tx_busy));

    a_r9_force_single: assert property (@(posedge clk) disable iff (!rst_n)
        force_stuff_err |=> !force_stuff_err);

    a_r11_sof_stops: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> !tx_busy);
endmodule

bind iso_in_ep_buf iso_in_ep_buf_checker #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/iso_in_ep_buf_bench.sv
module iso_in_ep_buf_bench;
    localparam int DEPTH = 64;
    localparam int LW    = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sof = 0, clear_ep = 0, wr_en = 0, in_token = 0, rd_strobe = 0, tx_done = 0;
    logic [7:0] wr_data = '0;
    logic tx_busy, force_stuff_err, miss_in, hs_stall, hs_nak, hs_ack, hs_irq;
    logic [LW-1:0] tx_len;
    logic [7:0] tx_data;

    always #2 clk = ~clk;

    iso_in_ep_buf #(.DEPTH(DEPTH)) u_iso_in_ep_buf (
        .clk(clk), .rst_n(rst_n), .sof(sof), .clear_ep(clear_ep),
        .wr_en(wr_en), .wr_data(wr_data), .in_token(in_token),
        .rd_strobe(rd_strobe), .tx_done(tx_done), .tx_busy(tx_busy),
        .tx_len(tx_len), .tx_data(tx_data), .force_stuff_err(force_stuff_err),
        .miss_in(miss_in), .hs_stall(hs_stall), .hs_nak(hs_nak),
        .hs_ack(hs_ack), .hs_irq(hs_irq)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] fg_m[$];
    logic [7:0] bg_m[$];
    logic [7:0] exp_q[$];

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: compare each strobed byte with the scoreboard head.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rd_strobe && tx_busy) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R2 unexpected byte", tx_data, -1);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(tx_data == e, "R2/R5 byte", tx_data, e);
                end
            end
        end
    end

    // Driver cycle: set inputs at negedge and update the data model.
    task automatic cyc(bit s, bit c, bit w, logic [7:0] d, bit tok, bit st, bit dn);
        @(negedge clk);
        sof = s; clear_ep = c; wr_en = w; wr_data = d;
        in_token = tok; rd_strobe = st; tx_done = dn;
        if (c) begin
            fg_m = {};
            bg_m = {};
        end else if (s) begin
            bg_m = fg_m;
            fg_m = {};
            if (w) fg_m.push_back(d);
        end else if (w && fg_m.size() < DEPTH) begin
            fg_m.push_back(d);
        end
    endtask

    task automatic idle();
        cyc(0, 0, 0, 8'h00, 0, 0, 0);
    endtask

    task automatic wr(logic [7:0] d);
        cyc(0, 0, 1, d, 0, 0, 0);
    endtask

    task automatic drain(int n);
        cyc(0, 0, 0, 8'h00, 1, 0, 0);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(k < bg_m.size() ? bg_m[k] : 8'h00);
            cyc(0, 0, 0, 8'h00, 0, 1, 0);
        end
    endtask

    task automatic hs_zero();
        chk({hs_stall, hs_nak, hs_ack, hs_irq} == 4'b0, "R10 handshake", {hs_stall, hs_nak, hs_ack, hs_irq}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R1: reset state
        chk(tx_busy == 0, "R1 busy", tx_busy, 0);
        chk(miss_in == 0, "R1 miss", miss_in, 0);
        chk(force_stuff_err == 0, "R1 force", force_stuff_err, 0);
        chk(tx_len == 0, "R1 len", tx_len, 0);
        hs_zero();

        // R2: short packet, full drain
        for (int i = 0; i < 5; i++) wr(8'(8'hA0 + i));
        cyc(1, 0, 0, 8'h00, 0, 0, 0);
        idle();
        chk(tx_len == 5, "R2 len", tx_len, 5);
        drain(5);
        idle();
        chk(tx_busy == 1, "R5 busy during drain", tx_busy, 1);
        cyc(0, 0, 0, 8'h00, 0, 0, 1);
        idle();
        chk(tx_busy == 0, "R6 done ends", tx_busy, 0);
        cyc(0, 0, 0, 8'h00, 1, 0, 0);
        idle();
        chk(tx_busy == 0, "R6 second token ignored", tx_busy, 0);
        hs_zero();

        // R4/R7: sent frame, empty new background
        cyc(1, 0, 0, 8'h00, 0, 0, 0);
        idle();
        chk(miss_in == 0, "R7 no miss after send", miss_in, 0);
        chk(tx_len == 0, "R4 new bank empty", tx_len, 0);

        // R3: overfill, then R11 abort by sof
        for (int i = 0; i < 70; i++) wr(8'(i * 3 + 1));
        cyc(1, 0, 0, 8'h00, 0, 0, 0);
        idle();
        chk(tx_len == DEPTH, "R3 len capped", tx_len, DEPTH);
        drain(66);
        idle();
        chk(tx_data == 0, "R5 data past length", tx_data, 0);
        cyc(1, 0, 0, 8'h00, 0, 0, 0);
        idle();
        chk(tx_busy == 0, "R11 sof stops", tx_busy, 0);
        chk(miss_in == 1, "R11 miss on abort", miss_in, 1);
        repeat (3) idle();
        chk(miss_in == 1, "R7 miss held", miss_in, 1);
        cyc(1, 0, 0, 8'h00, 0, 0, 0);
        idle();
        chk(miss_in == 0, "R7 miss cleared", miss_in, 0);

        // R4: write in sof cycle; R7: no token at all
        wr(8'h11); wr(8'h22); wr(8'h33);
        cyc(1, 0, 1, 8'h44, 0, 0, 0);
        idle();
        chk(tx_len == 3, "R4 len before", tx_len, 3);
        wr(8'h55);
        cyc(1, 0, 0, 8'h00, 0, 0, 0);
        idle();
        chk(miss_in == 1, "R7 miss no token", miss_in, 1);
        chk(tx_len == 2, "R4 sof-cycle byte kept", tx_len, 2);
        drain(2);
        cyc(0, 0, 0, 8'h00, 0, 0, 1);
        idle();

        // R8: clear while idle drops both banks and same-cycle write
        cyc(1, 0, 0, 8'h00, 0, 0, 0);
        for (int i = 0; i < 4; i++) wr(8'(8'hC0 + i));
        cyc(1, 0, 0, 8'h00, 0, 0, 0);
        wr(8'hD0); wr(8'hD1);
        cyc(0, 1, 1, 8'hEE, 0, 0, 0);
        idle();
        chk(tx_len == 0, "R8 len after clear", tx_len, 0);
        chk(force_stuff_err == 0, "R9 idle clear no force", force_stuff_err, 0);
        cyc(1, 0, 0, 8'h00, 0, 0, 0);
        idle();
        chk(tx_len == 0, "R8 next frame empty", tx_len, 0);
        chk(miss_in == 0, "R8 no miss after clear", miss_in, 0);

        // R9: clear during drain
        wr(8'h01); wr(8'h02); wr(8'h03);
        cyc(1, 0, 0, 8'h00, 0, 0, 0);
        drain(1);
        cyc(0, 1, 0, 8'h00, 0, 0, 0);
        idle();
        chk(force_stuff_err == 1, "R9 force pulse", force_stuff_err, 1);
        chk(tx_busy == 0, "R9 transfer cancelled", tx_busy, 0);
        idle();
        chk(force_stuff_err == 0, "R9 force one cycle", force_stuff_err, 0);

        // R12: clear coincident with sof while data pending
        wr(8'h09); wr(8'h0A);
        cyc(1, 0, 0, 8'h00, 0, 0, 0);
        wr(8'h0B);
        cyc(1, 1, 0, 8'h00, 0, 0, 0);
        idle();
        chk(miss_in == 0, "R12 miss cleared", miss_in, 0);
        chk(tx_len == 0, "R12 banks empty", tx_len, 0);
        hs_zero();

        chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule